// File: doc/BRIEF.md
# Timer-Paced ADC Capture Ring

This block paces an external converter from the system clock. A reloadable down-ratio counter fires once per period, and that tick drives the converter's start line directly. The moment a sample is taken is therefore fixed by the counter alone. The speed at which software or a downstream engine collects results never shifts it. With a 64 MHz clock and the reset reload value, the sample rate is about 13.2 kHz. That gives eleven samples per 1200-baud symbol, which suits tone-discriminating demodulators.

After each start, the block waits for the converter's end-of-conversion strobe and takes the 12-bit offset-binary result. It converts the result to a signed 16-bit value and writes it into a circular store of 256 entries. A consumer drains the store through a simple head-of-queue read port that keeps its own pointer. The consumer is told that work is ready once for every 64 samples stored, not once per sample.

Two sticky conditions are reported, and each stays set until reset. The first marks a sample dropped because the store was full. The second marks a conversion that never reported completion before the next tick.

Top module: `adc_ring_sampler`

## Requirements
- R1: After reset the reload value is 4847, so `convStart` rises once every 4848 clock cycles.
- R2: A write of `reloadIn` (one cycle of `reloadWe`) sets the reload value to N, restarts the counter at zero, and makes `convStart` occur at the 20th cycle after the write cycle for N=19. From then on the period is N+1 cycles.
- R3: `convStart` is high for exactly one cycle per period, whatever the state of the store or the consumer.
- R4: When `adcEoc` is high while a conversion is pending, `adcData` is stored as its value minus 2048, in two's complement and sign-extended to 16 bits. For example, 0 becomes 0xF800, 4095 becomes 0x07FF and 2048 becomes 0x0000.
- R5: `blockReady` is high for one cycle, in the cycle after the 64th, 128th, ... stored sample counted since reset. Samples that are dropped or skipped do not count.
- R6: When 256 samples are unread, a new result is discarded and `overrun` becomes 1 and stays 1 until reset. The 256 stored samples are still read back intact and in order.
- R7: `rdData` shows the oldest unread sample, and `rdEmpty` is 1 when there is none. A cycle of `rdReq` with data present retires the head. `rdReq` while empty has no effect.
- R8: When a new tick arrives while the previous conversion has not reported completion, `eocMissed` becomes 1 (sticky until reset) and nothing is stored for the missed slot.
- R9: An `adcEoc` pulse with no conversion pending stores nothing.
- R10: During reset `rdEmpty` is 1, and `convStart`, `blockReady`, `overrun` and `eocMissed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reloadWe | input | 1 | Load `reloadIn` as the counter reload and restart the counter |
| reloadIn | input | 16 | New reload value (period minus one) |
| adcEoc | input | 1 | Converter end-of-conversion strobe |
| adcData | input | 12 | Converter result, offset binary |
| rdReq | input | 1 | Consumer retires the head sample |
| convStart | output | 1 | Start-of-conversion pulse, one per period |
| rdData | output | 16 | Oldest unread signed sample |
| rdEmpty | output | 1 | No unread sample |
| blockReady | output | 1 | One-cycle pulse per 64 stored samples |
| overrun | output | 1 | Sticky: a sample was dropped on a full store |
| eocMissed | output | 1 | Sticky: a conversion did not complete before the next tick |

## Verification
The checker's period model assumes that the reload value is changed only through the `reloadWe` strobe. It tracks the counter phase from that strobe and from `convStart` alone. The ready-pulse property relies on the consumer never pulling more than one head per cycle.

The stimulus stays inside these assumptions. Reload writes are single-cycle, and the converter model answers a few cycles after each start, well inside a period. The only stray end-of-conversion pulses are driven on purpose, at points where no conversion is outstanding.

// File: rtl/adc_ring_pkg.sv
package adc_ring_pkg;
  // Strobes sent from the pacing control to the capture datapath.
  typedef struct packed {
    logic capture;  // a pending conversion completed this cycle
    logic miss;     // a tick arrived with a conversion still outstanding
  } strobe_t;
endpackage

// File: rtl/adc_ring_ctrl.sv
module adc_ring_ctrl
  import adc_ring_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RELOAD_RST = 4847
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reloadWe,
  input  logic [CNT_W-1:0] reloadIn,
  input  logic             adcEoc,
  output logic             convStart,
  output strobe_t          strobe,
  output logic             eocMissed
);
  localparam logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(RELOAD_RST);

  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] divCnt;
  logic             pending;
  logic             tick;

  assign tick      = (divCnt == reloadReg);
  assign convStart = tick;

  always_comb begin
    strobe.capture = pending & adcEoc;
    strobe.miss    = pending & ~adcEoc & tick;
  end

  // Divider: counts 0..reloadReg, restarts on a reload write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= RELOAD_INIT;
      divCnt    <= '0;
    end else if (reloadWe) begin
      reloadReg <= reloadIn;
      divCnt    <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  // Conversion bookkeeping: a tick opens a conversion, EOC closes it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      eocMissed <= 1'b0;
    end else begin
      if (tick)                pending <= 1'b1;
      else if (strobe.capture) pending <= 1'b0;
      if (strobe.miss)         eocMissed <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_ring_dp.sv
module adc_ring_dp
  import adc_ring_pkg::*;
#(
  parameter int ADC_W    = 12,
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 256,
  parameter int BLOCK    = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [ADC_W-1:0]    adcData,
  input  logic                rdReq,
  output logic [SAMPLE_W-1:0] rdData,
  output logic                rdEmpty,
  output logic                blockReady,
  output logic                overrun
);
  localparam int AW    = $clog2(DEPTH);
  localparam int BW    = $clog2(BLOCK);
  localparam int EXT_W = SAMPLE_W - ADC_W;
  localparam logic [BW-1:0] BLK_LAST = BW'(BLOCK - 1);

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW:0]         wrPtr, rdPtr;
  logic [BW-1:0]       blkCnt;
  logic [SAMPLE_W-1:0] sampleIn;
  logic                full, doWrite, doRead;

  // Offset binary to two's complement: flip the MSB, extend the new sign.
  assign sampleIn = {{EXT_W{~adcData[ADC_W-1]}}, ~adcData[ADC_W-1], adcData[ADC_W-2:0]};

  assign rdEmpty = (wrPtr == rdPtr);
  assign full    = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign doWrite = strobe.capture & ~full;
  assign doRead  = rdReq & ~rdEmpty;
  assign rdData  = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr[AW-1:0]] <= sampleIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      blkCnt     <= '0;
      blockReady <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (doWrite) begin
        wrPtr  <= wrPtr + 1'b1;
        blkCnt <= blkCnt + 1'b1;
      end
      if (doRead) rdPtr <= rdPtr + 1'b1;
      blockReady <= doWrite && (blkCnt == BLK_LAST);
      if (strobe.capture && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_ring_sampler.sv
module adc_ring_sampler
  import adc_ring_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RELOAD_RST = 4847,
  parameter int ADC_W      = 12,
  parameter int SAMPLE_W   = 16,
  parameter int DEPTH      = 256,
  parameter int BLOCK      = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reloadWe,
  input  logic [CNT_W-1:0]    reloadIn,
  input  logic                adcEoc,
  input  logic [ADC_W-1:0]    adcData,
  input  logic                rdReq,
  output logic                convStart,
  output logic [SAMPLE_W-1:0] rdData,
  output logic                rdEmpty,
  output logic                blockReady,
  output logic                overrun,
  output logic                eocMissed
);
  strobe_t strobe;

  adc_ring_ctrl #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .reloadWe(reloadWe), .reloadIn(reloadIn),
    .adcEoc(adcEoc), .convStart(convStart), .strobe(strobe), .eocMissed(eocMissed)
  );

  adc_ring_dp #(.ADC_W(ADC_W), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .BLOCK(BLOCK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adcData(adcData), .rdReq(rdReq),
    .rdData(rdData), .rdEmpty(rdEmpty), .blockReady(blockReady), .overrun(overrun)
  );
endmodule

// File: rtl/adc_ring_sampler_chk.sv
module adc_ring_sampler_chk #(
  parameter int CNT_W      = 16,
  parameter int RELOAD_RST = 4847
) (
  input logic             clk,
  input logic             rstN,
  input logic             reloadWe,
  input logic [CNT_W-1:0] reloadIn,
  input logic             convStart,
  input logic             rdEmpty,
  input logic             blockReady,
  input logic             overrun,
  input logic             eocMissed
);
  // Shadow of the period phase, rebuilt from the port-level events only.
  logic [CNT_W-1:0] gap;
  logic [CNT_W-1:0] shadowReload;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap          <= '0;
      shadowReload <= CNT_W'(RELOAD_RST);
    end else begin
      if (reloadWe) shadowReload <= reloadIn;
      if (reloadWe || convStart) gap <= '0;
      else                       gap <= gap + 1'b1;
    end
  end

  p_tick_on_phase_r1: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (gap == shadowReload));
  p_phase_gives_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (gap == shadowReload) |-> convStart);
  p_block_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    blockReady |=> !blockReady);
  p_block_has_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    blockReady |-> !rdEmpty);
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  p_missed_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    eocMissed |=> eocMissed);
endmodule

bind adc_ring_sampler adc_ring_sampler_chk #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_chk (
  .clk(clk), .rstN(rstN), .reloadWe(reloadWe), .reloadIn(reloadIn),
  .convStart(convStart), .rdEmpty(rdEmpty), .blockReady(blockReady),
  .overrun(overrun), .eocMissed(eocMissed)
);

// File: tb/adc_ring_sampler_tb.sv
module adc_ring_sampler_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reloadWe = 1'b0;
  logic [15:0] reloadIn = '0;
  logic        modelEoc = 1'b0, spurEoc = 1'b0;
  logic [11:0] modelData = '0, spurData = '0;
  logic        consRd = 1'b0, forceRd = 1'b0;
  logic        adcEoc, rdReq;
  logic [11:0] adcData;
  logic        convStart, rdEmpty, blockReady, overrun, eocMissed;
  logic [15:0] rdData;

  logic [15:0] q[$];
  int nChecks = 0, nFails = 0;
  int pushed = 0, drops = 0, blkPulses = 0, seqIdx = 0;
  bit respond = 0, consumeEn = 0;

  assign adcEoc  = modelEoc | spurEoc;
  assign adcData = spurEoc ? spurData : modelData;
  assign rdReq   = consRd | forceRd;

  always #2 clk = ~clk;

  adc_ring_sampler u_dut (
    .clk(clk), .rstN(rstN), .reloadWe(reloadWe), .reloadIn(reloadIn),
    .adcEoc(adcEoc), .adcData(adcData), .rdReq(rdReq), .convStart(convStart),
    .rdData(rdData), .rdEmpty(rdEmpty), .blockReady(blockReady),
    .overrun(overrun), .eocMissed(eocMissed)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] nextData(input int k);
    case (k)
      0: return 12'd0;
      1: return 12'd4095;
      2: return 12'd2048;
      3: return 12'd2047;
      default: return 12'((k * 1237 + 5) % 4096);
    endcase
  endfunction

  task automatic waitConv();
    do @(negedge clk); while (!convStart);
  endtask

  task automatic measurePeriod(output int n);
    waitConv();
    @(negedge clk);
    check(convStart == 1'b0, "R3 start width", convStart, 0);
    n = 1;
    while (!convStart) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic writeReload(input int v);
    @(negedge clk);
    reloadIn = 16'(v);
    reloadWe = 1'b1;
    @(negedge clk);
    reloadWe = 1'b0;
  endtask

  task automatic doReset();
    respond = 0;
    repeat (30) @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    q.delete();
    pushed = 0; drops = 0; blkPulses = 0;
    rstN = 1'b1;
  endtask

  // Converter model: answers three cycles after each start, feeds the scoreboard.
  initial forever begin
    @(negedge clk);
    if (rstN && convStart && respond) begin
      logic [11:0] d;
      d = nextData(seqIdx);
      seqIdx++;
      repeat (3) @(negedge clk);
      modelData = d;
      modelEoc  = 1'b1;
      if (!consumeEn && q.size() >= 256) drops++;
      else begin
        q.push_back(16'(int'(d) - 2048));
        pushed++;
      end
      @(negedge clk);
      modelEoc = 1'b0;
    end
  end

  // Monitor: pops the expected head and compares it with the read port.
  initial forever begin
    @(negedge clk);
    consRd = 1'b0;
    if (rstN && consumeEn && !rdEmpty) begin
      if (q.size() == 0) check(1'b0, "R7 unexpected sample", int'(rdData), -1);
      else begin
        logic [15:0] e;
        e = q.pop_front();
        check(rdData == e, "R4 sample value", int'(rdData), int'(e));
      end
      consRd = 1'b1;
    end
  end

  // Block-ready pulses must line up with every 64th stored sample.
  initial forever begin
    @(negedge clk);
    if (rstN && blockReady) begin
      blkPulses++;
      check(pushed > 0 && pushed % 64 == 0, "R5 pulse position", pushed % 64, 0);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(rdEmpty == 1'b1, "R10 rdEmpty", rdEmpty, 1);
    check(convStart == 1'b0, "R10 convStart", convStart, 0);
    check(blockReady == 1'b0, "R10 blockReady", blockReady, 0);
    check(overrun == 1'b0 && eocMissed == 1'b0, "R10 flags", {overrun, eocMissed}, 0);
    rstN = 1'b1;
    respond = 1; consumeEn = 1;

    // R1: default period
    measurePeriod(n);
    check(n == 4848, "R1 default period", n, 4848);

    // R2: reload write restarts the count
    @(negedge clk);
    reloadIn = 16'd19;
    reloadWe = 1'b1;
    n = 0;
    @(negedge clk);
    reloadWe = 1'b0;
    n = 1;
    while (!convStart) begin
      @(negedge clk);
      n++;
    end
    check(n == 20, "R2 first tick after write", n, 20);
    measurePeriod(n);
    check(n == 20, "R2 programmed period", n, 20);

    // R4/R5: stream enough samples to cross two block boundaries
    wait (pushed >= 140);
    repeat (30) @(negedge clk);
    check(blkPulses == pushed / 64, "R5 pulse count", blkPulses, pushed / 64);

    // R7: read request on an empty store is ignored
    respond = 0;
    repeat (40) @(negedge clk);
    check(rdEmpty == 1'b1 && q.size() == 0, "R7 drained", rdEmpty, 1);
    forceRd = 1'b1;
    repeat (3) @(negedge clk);
    forceRd = 1'b0;
    @(negedge clk);
    check(rdEmpty == 1'b1, "R7 empty read ignored", rdEmpty, 1);
    respond = 1;
    n = pushed;
    wait (pushed == n + 3);

    // R9: stray end-of-conversion with nothing pending
    repeat (3) @(negedge clk);
    spurData = 12'd100;
    spurEoc  = 1'b1;
    @(negedge clk);
    spurEoc = 1'b0;
    respond = 0;
    repeat (40) @(negedge clk);
    check(rdEmpty == 1'b1 && q.size() == 0, "R9 stray strobe stored nothing", rdEmpty, 1);

    // R6: fill the store, then overflow it
    doReset();
    writeReload(19);
    consumeEn = 0;
    respond = 1;
    wait (pushed == 256);
    repeat (3) @(negedge clk);
    check(overrun == 1'b0, "R6 no overrun at 256", overrun, 0);
    wait (drops == 1);
    repeat (3) @(negedge clk);
    check(overrun == 1'b1, "R6 overrun on drop", overrun, 1);
    wait (drops == 3);
    respond = 0;
    consumeEn = 1;
    repeat (400) @(negedge clk);
    check(rdEmpty == 1'b1 && q.size() == 0, "R6 stored samples drained", q.size(), 0);
    check(overrun == 1'b1, "R6 overrun sticky", overrun, 1);

    // R8: a conversion that never completes
    doReset();
    writeReload(19);
    respond = 1;
    wait (pushed >= 2);
    respond = 0;
    waitConv();
    @(negedge clk);
    respond = 1;
    check(eocMissed == 1'b0, "R8 no miss yet", eocMissed, 0);
    waitConv();
    @(negedge clk);
    check(eocMissed == 1'b1, "R8 miss flagged", eocMissed, 1);
    respond = 0;
    repeat (60) @(negedge clk);
    check(rdEmpty == 1'b1 && q.size() == 0, "R8 skipped slot stored nothing", rdEmpty, 1);
    check(eocMissed == 1'b1, "R8 miss sticky", eocMissed, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule